// File: doc/BRIEF.md
# Fixed-Point Rounding Stage with Status Flags

This block is the rounding step of a DSP arithmetic pipeline. It accepts a 40-bit two's-complement operand: a 32-bit fixed-point value with eight extension bits above it. It rounds the operand to its upper 24 bits. To do so it adds one half of the weight of bit 16 (the constant 0x0000_8000) across the whole 40-bit word and then forces the low 16 bits to zero. The sum wraps modulo 2^40 and is never saturated, so a carry can run all the way up through the extension bits.

Every accepted operation also produces five status flags: a carry flag (`dc`), a sign flag (`neg`), a zero flag (`zero`), an overflow flag (`ovf`, always 0 here) and a positive flag (`pos`). None of them is ever suppressed.

The result and flags are captured in a single output register. That register loads on the clock edge where `in_vld` is high, and `out_vld` reports that a new value arrived. A surrounding pipeline uses the block as its final stage: it presents an operand with `in_vld` and reads the outcome one clock later.

Top module: `dsp_round_unit`

## Requirements
- R1: On a clock where `in_vld` is 1, the next `out_res` equals `((in_opnd + 0x0000_8000) mod 2^40)` with bits 15..0 forced to 0.
- R2: Bits 15..0 of `out_res` are always 0.
- R3: `out_dc` is the carry out of bit 39 of the 41-bit sum `in_opnd + 0x8000`.
- R4: `out_neg` equals bit 39 of the rounded result.
- R5: `out_zero` is 1 exactly when all 40 bits of the rounded result are 0.
- R6: `out_ovf` is 0 after every rounding operation.
- R7: `out_pos` is 1 exactly when the rounded result is non-negative and non-zero.
- R8: `out_vld` equals `in_vld` from the previous clock edge, so the result and flags appear one clock after the operand is accepted.
- R9: While `in_vld` is 0, `out_res` and all flags keep their values whatever `in_opnd` does.
- R10: A synchronous active-high `rst` clears `out_vld`, `out_res` and all five flags to 0.
- R11: Input 0x7F_FFFF_FFFF yields 0x80_0000_0000 with `out_neg`=1 and `out_dc`=0. Input 0xFF_FFFF_8000 yields 0 with `out_zero`=1 and `out_dc`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand valid; loads the output register |
| in_opnd | input | 40 | Signed operand: 8 extension bits and a 32-bit value |
| out_vld | output | 1 | New result present this cycle |
| out_res | output | 40 | Rounded result, low 16 bits zero |
| out_dc | output | 1 | Carry out of bit 39 |
| out_neg | output | 1 | Result negative |
| out_zero | output | 1 | Result zero |
| out_ovf | output | 1 | Overflow, always 0 |
| out_pos | output | 1 | Result strictly positive |

## Verification
Directed operands cover the following cases:
- low words just below and at 0x8000, which separate round-down from round-up;
- all-ones upper bits with bit 15 set, which check the carry running through the extension bits into `out_dc` and to zero;
- the most positive value, which checks the wrap to a negative result;
- zero and small negatives, which separate `out_zero` from `out_pos`.

Random operands, half of them with the low word biased near the 0x8000 threshold, compare the result and every flag against a bench model. Idle cycles with a changing operand show that the register holds its value. Back-to-back valid cycles and a mid-run reset check the timing and the cleared state.

// File: rtl/dsp_round_pkg.sv
`timescale 1ns/1ps
package dsp_round_pkg;

    localparam int unsigned RND_DATA_W = 40;
    localparam int unsigned RND_CUT_W  = 16;

    typedef struct packed {
        logic dc;
        logic neg;
        logic zero;
        logic ovf;
        logic pos;
    } rnd_flags_t;

    localparam rnd_flags_t RND_FLAGS_CLR = '{dc: 1'b0, neg: 1'b0, zero: 1'b0, ovf: 1'b0, pos: 1'b0};

    function automatic rnd_flags_t mk_flags(input logic carry, input logic sign, input logic is_zero);
        rnd_flags_t f;
        f.dc   = carry;
        f.neg  = sign;
        f.zero = is_zero;
        f.ovf  = 1'b0;
        f.pos  = !sign && !is_zero;
        return f;
    endfunction

endpackage

// File: rtl/dsp_round_add.sv
`timescale 1ns/1ps
module dsp_round_add #(
    parameter int unsigned W   = dsp_round_pkg::RND_DATA_W,
    parameter int unsigned CUT = dsp_round_pkg::RND_CUT_W
) (
    input  logic [W-1:0] opnd,
    output logic [W-1:0] rounded,
    output logic         carry
);
    localparam logic [W:0]   HALF = (W+1)'(1) << (CUT - 1);
    localparam logic [W-1:0] KEEP = {{(W-CUT){1'b1}}, {CUT{1'b0}}};

    logic [W:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, opnd} + HALF;
        rounded  = wide_sum[W-1:0] & KEEP;
        carry    = wide_sum[W];
    end
endmodule

// File: rtl/dsp_round_flags.sv
`timescale 1ns/1ps
module dsp_round_flags #(
    parameter int unsigned W = dsp_round_pkg::RND_DATA_W
) (
    input  logic                      carry,
    input  logic [W-1:0]              rounded,
    output dsp_round_pkg::rnd_flags_t flags
);
    always_comb begin
        flags = dsp_round_pkg::mk_flags(carry, rounded[W-1], rounded == '0);
    end
endmodule

// File: rtl/dsp_round_reg.sv
`timescale 1ns/1ps
module dsp_round_reg #(
    parameter int unsigned W = dsp_round_pkg::RND_DATA_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [W-1:0]              res_d,
    input  dsp_round_pkg::rnd_flags_t flg_d,
    output logic                      vld_q,
    output logic [W-1:0]              res_q,
    output dsp_round_pkg::rnd_flags_t flg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
            flg_q <= dsp_round_pkg::RND_FLAGS_CLR;
        end else begin
            vld_q <= load;
            if (load) begin
                res_q <= res_d;
                flg_q <= flg_d;
            end
        end
    end
endmodule

// File: rtl/dsp_round_unit.sv
`timescale 1ns/1ps
module dsp_round_unit #(
    parameter int unsigned W   = dsp_round_pkg::RND_DATA_W,
    parameter int unsigned CUT = dsp_round_pkg::RND_CUT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [W-1:0] in_opnd,
    output logic         out_vld,
    output logic [W-1:0] out_res,
    output logic         out_dc,
    output logic         out_neg,
    output logic         out_zero,
    output logic         out_ovf,
    output logic         out_pos
);
    logic [W-1:0]              rnd_val;
    logic                      rnd_cy;
    dsp_round_pkg::rnd_flags_t flg_comb;
    dsp_round_pkg::rnd_flags_t flg_reg;

    dsp_round_add #(.W(W), .CUT(CUT)) u_add (
        .opnd    (in_opnd),
        .rounded (rnd_val),
        .carry   (rnd_cy)
    );

    dsp_round_flags #(.W(W)) u_flags (
        .carry   (rnd_cy),
        .rounded (rnd_val),
        .flags   (flg_comb)
    );

    dsp_round_reg #(.W(W)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .load  (in_vld),
        .res_d (rnd_val),
        .flg_d (flg_comb),
        .vld_q (out_vld),
        .res_q (out_res),
        .flg_q (flg_reg)
    );

    assign out_dc   = flg_reg.dc;
    assign out_neg  = flg_reg.neg;
    assign out_zero = flg_reg.zero;
    assign out_ovf  = flg_reg.ovf;
    assign out_pos  = flg_reg.pos;
endmodule

// File: rtl/dsp_round_unit_chk.sv
`timescale 1ns/1ps
module dsp_round_unit_chk #(
    parameter int unsigned W   = dsp_round_pkg::RND_DATA_W,
    parameter int unsigned CUT = dsp_round_pkg::RND_CUT_W
) (
    input logic         clk,
    input logic         rst,
    input logic         in_vld,
    input logic [W-1:0] in_opnd,
    input logic         out_vld,
    input logic [W-1:0] out_res,
    input logic         out_dc,
    input logic         out_neg,
    input logic         out_zero,
    input logic         out_ovf,
    input logic         out_pos
);
    logic loaded_q;

    always_ff @(posedge clk) begin
        if (rst)         loaded_q <= 1'b0;
        else if (in_vld) loaded_q <= 1'b1;
    end

    assert_low_clear_R2: assert property (@(posedge clk) disable iff (rst)
        out_res[CUT-1:0] == '0);

    assert_carry_zero_R3: assert property (@(posedge clk) disable iff (rst)
        loaded_q && out_dc |-> out_zero);

    assert_carry_in_R3: assert property (@(posedge clk) disable iff (rst)
        in_vld && (&in_opnd[W-1:CUT-1]) |=> out_dc);

    assert_sign_R4: assert property (@(posedge clk) disable iff (rst)
        loaded_q |-> out_neg == out_res[W-1]);

    assert_zero_R5: assert property (@(posedge clk) disable iff (rst)
        loaded_q |-> out_zero == (out_res == '0));

    assert_no_ovf_R6: assert property (@(posedge clk) disable iff (rst)
        !out_ovf);

    assert_pos_R7: assert property (@(posedge clk) disable iff (rst)
        loaded_q |-> out_pos == (!out_neg && !out_zero));

    assert_vld_on_R8: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    assert_vld_off_R8: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(out_res) && $stable({out_dc, out_neg, out_zero, out_pos}));

    assert_reset_R10: assert property (@(posedge clk)
        rst |=> !out_vld && out_res == '0 && !out_dc && !out_neg && !out_zero && !out_pos);
endmodule

bind dsp_round_unit dsp_round_unit_chk #(.W(W), .CUT(CUT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_opnd  (in_opnd),
    .out_vld  (out_vld),
    .out_res  (out_res),
    .out_dc   (out_dc),
    .out_neg  (out_neg),
    .out_zero (out_zero),
    .out_ovf  (out_ovf),
    .out_pos  (out_pos)
);

// File: tb/dsp_round_unit_test.sv
`timescale 1ns/1ps
module dsp_round_unit_test;
    localparam int unsigned W = 40;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_vld = 1'b0;
    logic [W-1:0] in_opnd = '0;
    logic         out_vld;
    logic [W-1:0] out_res;
    logic         out_dc, out_neg, out_zero, out_ovf, out_pos;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dsp_round_unit uut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_opnd(in_opnd),
        .out_vld(out_vld), .out_res(out_res), .out_dc(out_dc),
        .out_neg(out_neg), .out_zero(out_zero), .out_ovf(out_ovf), .out_pos(out_pos)
    );

    function automatic logic [W:0] model_sum(input logic [W-1:0] op);
        return {1'b0, op} + 41'h00_0000_8000;
    endfunction

    function automatic logic [W-1:0] model_res(input logic [W-1:0] op);
        logic [W:0] s;
        s = model_sum(op);
        return {s[W-1:16], 16'h0000};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(input logic [W-1:0] op);
        logic [W-1:0] r;
        r = model_res(op);
        check("R1 result", 64'(out_res), 64'(r));
        check("R2 low word", 64'(out_res[15:0]), 64'h0);
        check("R3 carry", 64'(out_dc), 64'(model_sum(op) >> W));
        check("R4 sign", 64'(out_neg), 64'(r[W-1]));
        check("R5 zero", 64'(out_zero), 64'(r == '0));
        check("R6 ovf", 64'(out_ovf), 64'h0);
        check("R7 pos", 64'(out_pos), 64'(!r[W-1] && r != '0));
        check("R8 valid", 64'(out_vld), 64'h1);
    endtask

    task automatic run_op(input logic [W-1:0] op);
        @(negedge clk);
        in_vld  = 1'b1;
        in_opnd = op;
        @(negedge clk);
        in_vld  = 1'b0;
        check_all(op);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] last_res;
        logic [4:0]   last_flg;
        logic [31:0]  a, b;

        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R10 reset vld", 64'(out_vld), 64'h0);
        check("R10 reset res", 64'(out_res), 64'h0);
        check("R10 reset flags", 64'({out_dc, out_neg, out_zero, out_ovf, out_pos}), 64'h0);
        rst = 1'b0;

        run_op(40'h00_1234_7FFF);
        run_op(40'h00_1234_8000);
        run_op(40'h00_0000_0000);
        run_op(40'hFF_FFFF_7FFF);
        run_op(40'hFF_FFFF_FFFF);
        run_op(40'h00_0000_8000);

        run_op(40'h7F_FFFF_FFFF);
        check("R11 max wraps", 64'(out_res), 64'h80_0000_0000);
        check("R11 max neg", 64'(out_neg), 64'h1);
        check("R11 max dc", 64'(out_dc), 64'h0);
        run_op(40'hFF_FFFF_8000);
        check("R11 to zero", 64'(out_res), 64'h0);
        check("R11 zero flag", 64'(out_zero), 64'h1);
        check("R11 dc flag", 64'(out_dc), 64'h1);

        // R9: hold while idle, operand changing
        last_res = out_res;
        last_flg = {out_dc, out_neg, out_zero, out_ovf, out_pos};
        for (int i = 0; i < 4; i++) begin
            in_opnd = 40'h12_3456_789A + 40'(i);
            @(negedge clk);
            check("R9 hold res", 64'(out_res), 64'(last_res));
            check("R9 hold flags", 64'({out_dc, out_neg, out_zero, out_ovf, out_pos}), 64'(last_flg));
            check("R8 idle valid", 64'(out_vld), 64'h0);
        end

        // R8: back-to-back operands
        @(negedge clk);
        in_vld = 1'b1; in_opnd = 40'h01_0000_8000;
        @(negedge clk);
        check_all(40'h01_0000_8000);
        in_opnd = 40'hF0_0000_4000;
        @(negedge clk);
        check_all(40'hF0_0000_4000);
        in_vld = 1'b0;

        // random, half with low word near the threshold
        for (int i = 0; i < 400; i++) begin
            a = $urandom();
            b = $urandom();
            if (i % 2 == 0) b[15:0] = 16'h7FF0 + 16'(a[4:0]);
            if (i % 5 == 0) a[7:0] = (a[8]) ? 8'hFF : 8'h7F;
            run_op({a[7:0], b});
        end

        // R10: mid-run reset
        @(negedge clk);
        in_vld = 1'b1; in_opnd = 40'h00_4000_0000; rst = 1'b1;
        @(negedge clk);
        check("R10 mid reset vld", 64'(out_vld), 64'h0);
        check("R10 mid reset res", 64'(out_res), 64'h0);
        check("R10 mid reset flags", 64'({out_dc, out_neg, out_zero, out_ovf, out_pos}), 64'h0);
        rst = 1'b0; in_vld = 1'b0;
        run_op(40'h00_4000_0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule